// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The three wires are a bit clock, a data line and a left/right select clock. All three are asynchronous to the block's own system clock, which must run several times faster than the bit clock. The block oversamples them through a synchronizer and reads one data bit on each rising bit-clock edge. The left/right level sampled at that same edge decides which channel the bit belongs to: high means left, low means right.

Words are two's complement. Each word is 16 or 18 bits long, and its bits arrive either most significant first or least significant first. Two static configuration inputs select the length and the bit order. The receiver keeps the most recent bits in a shift register. When the left/right level changes, the last word-length bits before the change are taken as the word of the half-frame that just ended. Because of this, a bit clock faster than the minimum only adds leading bits, and those are ignored.

A left half-frame followed by a right half-frame forms a frame. The rising left/right transition commits the frame: both 18-bit samples are presented together with a one-cycle valid pulse. A 16-bit word is placed in the upper 16 bits of the 18-bit sample, and its two low bits are zero.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is high and after it is released, left_smp and right_smp read zero and frame_vld is low.
- R2: A data bit is taken at each rising bck edge. An lrck level of 1 at that edge marks left-channel data and a level of 0 marks right-channel data. One system-clock pulse of frame_vld follows the rising lrck transition, with left_smp holding the word of the preceding high half and right_smp the word of the low half.
- R3: With cfg_wide=1 and cfg_lsb_first=0, an 18-bit word sent most significant bit first appears unchanged on the 18-bit sample.
- R4: With cfg_wide=1 and cfg_lsb_first=1, an 18-bit word sent least significant bit first appears unchanged on the 18-bit sample.
- R5: With cfg_wide=0 and cfg_lsb_first=0, a 16-bit word sent most significant bit first appears in sample bits [17:2], and bits [1:0] are 0.
- R6: With cfg_wide=0 and cfg_lsb_first=1, a 16-bit word sent least significant bit first appears in sample bits [17:2], and bits [1:0] are 0.
- R7: Only the last 18 (cfg_wide=1) or 16 (cfg_wide=0) bits before an lrck transition form the word. Bits received earlier in the same half have no effect on the sample.
- R8: A half-frame that carries exactly the word length in bits, which is the minimum bit clock of 32 or 36 per sample period, is received correctly.
- R9: frame_vld never stays high for two consecutive cycles, and left_smp and right_smp change only in a cycle where frame_vld is high.
- R10: A rising lrck transition gives no frame_vld unless a falling transition, which ends a left half, has been seen since reset or since the last committed frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Serial bit clock, asynchronous |
| dat_in | input | 1 | Serial data, two's complement |
| lrck_in | input | 1 | Left/right clock: 1 for left, 0 for right |
| cfg_wide | input | 1 | 1 selects 18-bit words, 0 selects 16-bit words |
| cfg_lsb_first | input | 1 | 1 for least significant bit first, 0 for most significant first |
| left_smp | output | 18 | Left sample of the last committed frame |
| right_smp | output | 18 | Right sample of the last committed frame |
| frame_vld | output | 1 | One-cycle pulse when a new frame is committed |

## Verification
The assertions check four things on every cycle. Bit strobes never occur on back-to-back cycles. The shift register takes exactly the strobed bit. The valid pulse is single-cycle, falls in a left half, and the samples change only with it. In 16-bit mode the low sample bits are zero. Only the bench scenarios can show that the words are assembled correctly in all four length and order combinations, that leading bits are discarded, that a minimum-length half is received, and that no frame is committed after reset until a left half has been completed.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int unsigned SAMPLE_W = 18;
  localparam int unsigned SHORT_W  = 16;
  localparam int unsigned PAD_W    = SAMPLE_W - SHORT_W;

  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef struct packed {
    logic wide;
    logic lsb_first;
  } fmt_t;
endpackage

// File: rtl/arx_edge_sync.sv
module arx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_raw,
  input  logic lrck_raw,
  input  logic dat_raw,
  output logic bit_stb,
  output logic bit_val,
  output logic lr_val
);
  localparam int unsigned LAST = STAGES - 1;

  // bit 2: bit clock, bit 1: left/right clock, bit 0: data
  logic [2:0] stg [STAGES];
  logic       bck_d;
  logic       rise;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= {bck_raw, lrck_raw, dat_raw};
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign rise = stg[LAST][2] & ~bck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_d   <= 1'b0;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
      lr_val  <= 1'b0;
    end else begin
      bck_d   <= stg[LAST][2];
      bit_stb <= rise;
      if (rise) begin
        bit_val <= stg[LAST][0];
        lr_val  <= stg[LAST][1];
      end
    end
  end

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/arx_word_shift.sv
module arx_word_shift
  import arx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bit_stb,
  input  logic    bit_val,
  input  fmt_t    fmt,
  output sample_t word
);
  logic [SAMPLE_W-1:0] sh;
  logic [SAMPLE_W-1:0] rev_full;
  logic [SHORT_W-1:0]  rev_short;

  always_ff @(posedge clk) begin
    if (rst)          sh <= '0;
    else if (bit_stb) sh <= {sh[SAMPLE_W-2:0], bit_val};
  end

  // newest bit sits in sh[0]; reversed views serve least-significant-first order
  for (genvar j = 0; j < SAMPLE_W; j++) begin : g_rev_full
    assign rev_full[j] = sh[SAMPLE_W-1-j];
  end

  for (genvar k = 0; k < SHORT_W; k++) begin : g_rev_short
    assign rev_short[k] = sh[SHORT_W-1-k];
  end

  always_comb begin
    case ({fmt.wide, fmt.lsb_first})
      2'b10:   word = sh;
      2'b11:   word = rev_full;
      2'b00:   word = {sh[SHORT_W-1:0], {PAD_W{1'b0}}};
      default: word = {rev_short, {PAD_W{1'b0}}};
    endcase
  end

  // R7
  shift_take_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> (sh[0] == $past(bit_val)) &&
                (sh[SAMPLE_W-1:1] == $past(sh[SAMPLE_W-2:0])));

endmodule

// File: rtl/arx_frame_commit.sv
module arx_frame_commit
  import arx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bit_stb,
  input  logic    lr_val,
  input  sample_t word,
  output sample_t left_smp,
  output sample_t right_smp,
  output logic    frame_vld
);
  logic    lr_q;
  logic    left_ok;
  sample_t left_hold;
  logic    edge_seen;

  assign edge_seen = bit_stb && (lr_val != lr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q      <= 1'b0;
      left_ok   <= 1'b0;
      left_hold <= '0;
      left_smp  <= '0;
      right_smp <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (bit_stb) lr_q <= lr_val;
      if (edge_seen) begin
        if (lr_q) begin
          // falling transition closes a left half
          left_hold <= word;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          // rising transition closes a right half and commits the pair
          left_smp  <= left_hold;
          right_smp <= word;
          frame_vld <= 1'b1;
          left_ok   <= 1'b0;
        end
      end
    end
  end

  // R9
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> !frame_vld);

  // R9
  smp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |-> ($stable(left_smp) && $stable(right_smp)));

  // R2
  vld_in_left_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> lr_q);

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import arx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bck_in,
  input  logic                dat_in,
  input  logic                lrck_in,
  input  logic                cfg_wide,
  input  logic                cfg_lsb_first,
  output logic [SAMPLE_W-1:0] left_smp,
  output logic [SAMPLE_W-1:0] right_smp,
  output logic                frame_vld
);
  logic    bit_stb;
  logic    bit_val;
  logic    lr_val;
  fmt_t    fmt;
  sample_t word;

  assign fmt.wide      = cfg_wide;
  assign fmt.lsb_first = cfg_lsb_first;

  arx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .bck_raw  (bck_in),
    .lrck_raw (lrck_in),
    .dat_raw  (dat_in),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .lr_val   (lr_val)
  );

  arx_word_shift u_shift (
    .clk     (clk),
    .rst     (rst),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .fmt     (fmt),
    .word    (word)
  );

  arx_frame_commit u_commit (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .lr_val    (lr_val),
    .word      (word),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .frame_vld (frame_vld)
  );

  // R5
  short_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && !$past(cfg_wide)) |-> (right_smp[PAD_W-1:0] == '0));

endmodule

// File: tb/audio_serial_rx_bench.sv
`timescale 1ns/1ps
module audio_serial_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck = 1'b0;
  logic        dat = 1'b0;
  logic        lrck = 1'b0;
  logic        wide = 1'b1;
  logic        lsbf = 1'b0;
  logic [17:0] left_smp;
  logic [17:0] right_smp;
  logic        frame_vld;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  audio_serial_rx u_audio_serial_rx (
    .clk           (clk),
    .rst           (rst),
    .bck_in        (bck),
    .dat_in        (dat),
    .lrck_in       (lrck),
    .cfg_wide      (wide),
    .cfg_lsb_first (lsbf),
    .left_smp      (left_smp),
    .right_smp     (right_smp),
    .frame_vld     (frame_vld)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] expect18(input logic [17:0] w, input logic is_wide);
    return is_wide ? w : {w[15:0], 2'b00};
  endfunction

  task automatic send_bit(input logic lr, input logic b);
    @(negedge clk);
    bck = 1'b0; lrck = lr; dat = b;
    repeat (4) @(negedge clk);
    bck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input logic lr, input logic [17:0] w, input int n,
                           input logic lsb, input int junk);
    for (int j = 0; j < junk; j++) send_bit(lr, j[0]);
    for (int i = 0; i < n; i++) send_bit(lr, w[lsb ? i : n - 1 - i]);
  endtask

  task automatic wait_vld(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 24; k++) begin
      if (frame_vld) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input string req, input logic [17:0] l, input logic [17:0] r,
                           input logic w_mode, input logic lsb, input int junk);
    logic seen;
    int   n;
    n = w_mode ? 18 : 16;
    wide = w_mode; lsbf = lsb;
    send_half(1'b1, l, n, lsb, junk);
    send_half(1'b0, r, n, lsb, junk);
    send_bit(1'b1, 1'b0);
    wait_vld(seen);
    chk({req, " R2 valid pulse"}, {17'b0, seen}, 18'd1);
    chk({req, " left"},  left_smp,  expect18(l, w_mode));
    chk({req, " right"}, right_smp, expect18(r, w_mode));
    @(negedge clk);
    chk({req, " R9 pulse width"}, {17'b0, frame_vld}, 18'd0);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    chk("R1 left reset",  left_smp,  18'd0);
    chk("R1 right reset", right_smp, 18'd0);
    chk("R1 valid reset", {17'b0, frame_vld}, 18'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid after release", {17'b0, frame_vld}, 18'd0);
  endtask

  task automatic t_no_left;
    logic seen;
    wide = 1'b1; lsbf = 1'b0;
    send_half(1'b0, 18'h12345, 18, 1'b0, 0);
    send_bit(1'b1, 1'b1);
    wait_vld(seen);
    chk("R10 no pulse without left half", {17'b0, seen}, 18'd0);
    chk("R10 right untouched", right_smp, 18'd0);
  endtask

  task automatic t_hold;
    logic [17:0] l0, r0;
    l0 = left_smp; r0 = right_smp;
    for (int i = 0; i < 10; i++) send_bit(1'b1, i[0]);
    chk("R9 left held", left_smp, l0);
    chk("R9 right held", right_smp, r0);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_no_left();
    run_frame("R3 R8 msb18", 18'h2A5C3, 18'h20001, 1'b1, 1'b0, 0);
    run_frame("R4 R8 lsb18", 18'h1F00E, 18'h3FFFE, 1'b1, 1'b1, 0);
    run_frame("R5 R8 msb16", 18'h08001, 18'h07FFE, 1'b0, 1'b0, 0);
    run_frame("R6 R8 lsb16", 18'h0C3A5, 18'h00001, 1'b0, 1'b1, 0);
    run_frame("R7 extra bits 18", 18'h35A5A, 18'h0F0F1, 1'b1, 1'b0, 6);
    run_frame("R7 extra bits 16", 18'h0FFFF, 18'h08000, 1'b0, 1'b1, 8);
    t_hold();
    run_frame("R2 swap check", 18'h00003, 18'h3FFF0, 1'b1, 1'b0, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule